// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a simple word-addressed register bus with separate read and write strobes. Software writes a period value, which also loads the live down-counter, then issues a start command through the control word. While running, the counter decrements once per clock. When the count expires, a timeout flag is raised.

In one-shot mode the counter halts at zero when it expires. In continuous mode it reloads from the stored period and keeps counting. A single level-sensitive interrupt follows the timeout flag, qualified by an enable bit. The running count can be sampled at any moment through a read-only snapshot register. Software acknowledges a timeout by writing anything to the status register.

Top module: `interval_timer`

## Requirements
- R1: After reset, status, control, period and snapshot all read 0, the interrupt is low, and the counter is stopped and holds its value until a period write.
- R2: A write to the period register (byte offset 0x8) stores the written word and loads it into the counter in the same clock edge. The period reads back as written.
- R3: Writing control (offset 0x4) with bit 2 set starts the counter. The counter then decrements by one on every clock. Status (offset 0x0) bit 1 reads 1 while the counter runs.
- R4: A running counter whose value is 1 (or 0) expires on the next edge. Expiry sets status bit 0. With control bit 1 clear, expiry leaves the counter at 0 and stopped.
- R5: With control bit 1 set, expiry sets status bit 0, reloads the counter from the period register, and the counter keeps running.
- R6: Writing control with bit 3 set stops the counter, which then holds its value. If bit 2 and bit 3 are both set in one write, the counter ends up stopped.
- R7: Any write to status clears status bit 0, whatever the written data.
- R8: The interrupt output is high exactly while status bit 0 and control bit 0 are both 1.
- R9: Writes to snapshot (offset 0xC) and any access to an unknown or misaligned offset change no state. Reads of unknown offsets return 0.
- R10: A read returns its data on the bus one clock after the read strobe. Control reads back its low four bits as last written, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt |

## Verification
The counter is exercised in three patterns: a one-shot countdown, a continuous run, and a run halted part-way. The one-shot countdown is sampled on several consecutive cycles through the snapshot register, which shows the per-clock decrement and the exact expiry cycle. The continuous run tells a reload from the period apart from a halt at zero. The halted run shows that a stop freezes the count, and that a combined start and stop command leaves the counter idle. Status acknowledges, interrupt masking, ignored snapshot and unknown-offset writes, and a reset taken mid-count are each checked separately against the register read-back.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NREG       = 4;
  localparam int IDX_STATUS = 0;
  localparam int IDX_CTRL   = 1;
  localparam int IDX_PERIOD = 2;
  localparam int IDX_SNAP   = 3;

  // control word, bit 0 in the lsb position
  typedef struct packed {
    logic halt;   // bit 3
    logic go;     // bit 2
    logic rearm;  // bit 1
    logic ien;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
  parameter int ADDR_W = 5,
  parameter int NREG   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NREG-1:0]   wr_hit,
  output logic [NREG-1:0]   rd_hit
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = wr && aligned && (widx == WIDX_W'(i));
    assign rd_hit[i] = rd && aligned && (widx == WIDX_W'(i));
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             start,
  input  logic             stop,
  input  logic             rearm,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] count_d;
  logic             running_d;

  assign expire = running && (count <= CNT_W'(1)) && !load;

  always_comb begin
    count_d = count;
    if (load) begin
      count_d = load_val;
    end else if (expire) begin
      count_d = rearm ? period : '0;
    end else if (running) begin
      count_d = count - CNT_W'(1);
    end
  end

  always_comb begin
    running_d = running;
    if (stop) begin
      running_d = 1'b0;
    end else if (start) begin
      running_d = 1'b1;
    end else if (expire && !rearm) begin
      running_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      count   <= count_d;
      running <= running_d;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import timer_pkg::*;

  localparam int CTRL_W = $bits(ctrl_t);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [NREG-1:0]   wr_hit, rd_hit;
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] period_q, period_d;
  logic              to_flag, to_flag_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] count;
  logic              running, expire;
  logic              cmd_start, cmd_stop;

  tmr_regdec #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  assign cmd_start = wr_hit[IDX_CTRL] && bus_wdata[2];
  assign cmd_stop  = wr_hit[IDX_CTRL] && bus_wdata[3];

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (wr_hit[IDX_PERIOD]),
    .load_val (bus_wdata),
    .start    (cmd_start),
    .stop     (cmd_stop),
    .rearm    (ctrl_q.rearm),
    .period   (period_q),
    .count    (count),
    .running  (running),
    .expire   (expire)
  );

  // next state of the stored registers
  always_comb begin
    ctrl_d    = ctrl_q;
    period_d  = period_q;
    to_flag_d = to_flag;
    if (wr_hit[IDX_CTRL])   ctrl_d   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    if (wr_hit[IDX_PERIOD]) period_d = bus_wdata;
    if (expire)                  to_flag_d = 1'b1;
    else if (wr_hit[IDX_STATUS]) to_flag_d = 1'b0;
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    unique case (1'b1)
      rd_hit[IDX_STATUS]: rdata_d = {{(DATA_W-2){1'b0}}, running, to_flag};
      rd_hit[IDX_CTRL]:   rdata_d = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      rd_hit[IDX_PERIOD]: rdata_d = period_q;
      rd_hit[IDX_SNAP]:   rdata_d = count;
      default:            rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctrl_q    <= '0;
      period_q  <= '0;
      to_flag   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      period_q <= period_d;
      to_flag  <= to_flag_d;
      if (bus_rd) bus_rdata <= rdata_d;
    end
  end

  assign irq = to_flag && ctrl_q.ien;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_status,
  input logic              wr_ctrl,
  input logic              wr_period,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] period_q,
  input logic              running,
  input logic              to_flag,
  input logic              ien,
  input logic              rearm,
  input logic              irq
);
  logic at_end;
  assign at_end = running && (count <= DATA_W'(1));

  // R1: an idle counter holds its value
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_period) |=> $stable(count));

  // R2: period write loads the counter
  a_r2_period_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_period |=> (count == $past(wdata)));

  // R3: one decrement per clock
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (running && count > DATA_W'(1) && !wr_period && !wr_ctrl)
      |=> (count == $past(count) - DATA_W'(1)));

  // R4: one-shot expiry stops at zero with the flag set
  a_r4_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !rearm && !wr_period && !wr_ctrl)
      |=> (!running && to_flag && count == '0));

  // R5: continuous expiry reloads from the period
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && rearm && !wr_period)
      |=> (to_flag && count == $past(period_q)));

  // R6: stop command always wins
  a_r6_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[3]) |=> !running);

  // R7: status write clears the flag when no expiry coincides
  a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !at_end) |=> !to_flag);

  // R8: interrupt needs the flag and the enable
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (to_flag && ien));
endmodule

bind interval_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .wr_status (wr_hit[0]),
  .wr_ctrl   (wr_hit[1]),
  .wr_period (wr_hit[2]),
  .wdata     (bus_wdata),
  .count     (count),
  .period_q  (period_q),
  .running   (running),
  .to_flag   (to_flag),
  .ien       (ctrl_q.ien),
  .rearm     (ctrl_q.rearm),
  .irq       (irq)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 22;
  // {op, addr, data, expected}
  localparam logic [70:0] VEC [NV] = '{
    {OP_RD,  5'h00, 32'h0, 32'h0},  // R1 status
    {OP_RD,  5'h04, 32'h0, 32'h0},  // R1 control
    {OP_RD,  5'h08, 32'h0, 32'h0},  // R1 period
    {OP_RD,  5'h0C, 32'h0, 32'h0},  // R1 snapshot
    {OP_WR,  5'h08, 32'h5, 32'h0},  // R2 period = 5
    {OP_RD,  5'h08, 32'h0, 32'h5},  // R2 period read
    {OP_RD,  5'h0C, 32'h0, 32'h5},  // R2 counter loaded
    {OP_WR,  5'h04, 32'h5, 32'h0},  // R3 enable + start
    {OP_RD,  5'h0C, 32'h0, 32'h5},  // R3 snapshot
    {OP_RD,  5'h00, 32'h0, 32'h2},  // R3 running bit
    {OP_RD,  5'h0C, 32'h0, 32'h3},  // R3 decrement
    {OP_IDLE,5'h00, 32'h0, 32'h0},
    {OP_IDLE,5'h00, 32'h0, 32'h0},  // expiry edge
    {OP_RD,  5'h00, 32'h0, 32'h1},  // R4 flag set, stopped
    {OP_IRQ, 5'h00, 32'h0, 32'h1},  // R8 irq high
    {OP_RD,  5'h0C, 32'h0, 32'h0},  // R4 count at zero
    {OP_WR,  5'h04, 32'h2, 32'h0},  // continuous, no enable
    {OP_IRQ, 5'h00, 32'h0, 32'h0},  // R8 masked
    {OP_RD,  5'h04, 32'h0, 32'h2},  // R10 control read-back
    {OP_RD,  5'h00, 32'h0, 32'h1},  // R8 flag still set
    {OP_WR,  5'h00, 32'hFFFFFFFF, 32'h0}, // R7 acknowledge
    {OP_RD,  5'h00, 32'h0, 32'h0}   // R7 flag cleared
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h, expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    v = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    logic [31:0] v, v2;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        OP_WR:  wr(a, d);
        OP_RD:  begin rd(a, v); check($sformatf("vector %0d R1-R10 read", i), v, e); end
        OP_IRQ: begin check($sformatf("vector %0d R8 irq", i), {31'b0, irq}, e); idle(1); end
        default: idle(1);
      endcase
    end

    // R5: continuous reload
    wr(5'h08, 32'd3);
    wr(5'h04, 32'h7);
    idle(3);
    rd(5'h00, v);  check("R5 status running+flag", v, 32'h3);
    rd(5'h0C, v);  check("R5 reloaded count", v, 32'h2);
    check("R8 irq in continuous", {31'b0, irq}, 32'h1);

    // R6: stop freezes count
    wr(5'h04, 32'h8);
    rd(5'h0C, v);
    idle(3);
    rd(5'h0C, v2); check("R6 count frozen", v2, v);
    rd(5'h00, v);  check("R6 not running", v & 32'h2, 32'h0);

    // R6: start and stop together
    wr(5'h00, 32'h0);
    wr(5'h08, 32'd10);
    wr(5'h04, 32'hC);
    idle(2);
    rd(5'h00, v);  check("R6 start+stop stays idle", v, 32'h0);
    rd(5'h0C, v);  check("R6 count untouched", v, 32'd10);

    // R9: snapshot write, unknown and misaligned offsets
    wr(5'h0C, 32'h1234);
    wr(5'h10, 32'h7);
    wr(5'h09, 32'h55);
    wr(5'h05, 32'h1);
    rd(5'h0C, v);  check("R9 snapshot write ignored", v, 32'd10);
    rd(5'h08, v);  check("R9 period unchanged", v, 32'd10);
    rd(5'h04, v);  check("R9 control unchanged", v, 32'hC);
    rd(5'h14, v);  check("R9 unknown read zero", v, 32'h0);

    // R1: reset taken mid-count
    wr(5'h08, 32'd50);
    wr(5'h04, 32'h5);
    idle(3);
    do_reset();
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(5'h00, v);  check("R1 status after reset", v, 32'h0);
    rd(5'h04, v);  check("R1 control after reset", v, 32'h0);
    rd(5'h08, v);  check("R1 period after reset", v, 32'h0);
    idle(2);
    rd(5'h0C, v);  check("R1 counter stopped", v, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule